// File: doc/BRIEF.md
# TDM time-slot interchange switch

This block reorders the byte time slots of serial time-division links. Two groups of receive streams, group A and group B, shift in one bit per clock, most significant bit first. Every completed channel byte is written into a data memory under its group, stream and channel number. The memory is banked by frame.

A group of transmit streams carries the output. For each transmit channel, the block looks up the entry for that stream and channel in a connection memory. The entry either routes a stored input byte, selected by group, stream and channel, or sends a constant byte taken from the entry itself. The entry also says whether the output slot is driven or released.

A small host port does three things. It writes and reads connection entries. It reads back received bytes. It sets a control bit that, together with an external enable pin, releases the serial outputs. The block needs `CHANS` to be a power of two and `NSTR` to be between 1 and 7.

Top module: `tsi_switch`

## Requirements
- R1: A frame has CHANS*8 bit periods, one bit per clock. `frame_sync` is high in the period that carries bit 7 of channel 0. Every channel is sent and received most significant bit first.
- R2: An entry with bit 15 = 0 and bit 14 = 1 routes a byte. The source is given by bit 13 (group: 0 = A, 1 = B), bits 12:9 (stream) and bits 8:0 (channel). Output channel c in frame N carries the byte received at that source in frame N-2. This holds for every pair of positions, including a source channel later in the frame than the output channel.
- R3: An entry with bit 15 = 1 sends its own bits 7:0. The group and stream fields are ignored, even when they are out of range.
- R4: An entry with bit 14 = 0 releases its slot. With `idle_hiz` = 0 the slot shows `tx_d` = 1 and `tx_oe` = 1. With `idle_hiz` = 1 it shows `tx_oe` = 0.
- R5: A slot is driven only while `out_en` = 1 and control bit 0 is 1. The control bit lives at region 3 and resets to 0. Otherwise every slot is released as in R4.
- R6: A routed entry whose stream is at least NSTR, or whose channel is at least CHANS, sends 0x00.
- R7: A host read with `hrd` at region 1 (group A) or region 2 (group B) returns the most recent byte received at index stream*CHANS+channel. The result appears on `hrdata` in the cycle after `hrd`, and bits 15:8 are zero.
- R8: A host write at region 0 stores an entry at index out_stream*CHANS+out_channel. During the first NSTR bit periods of every channel, `hbusy` is 1 and the write is held. The write completes on the first cycle that is free. Reading region 0 returns the stored entry.
- R9: After reset the control bit is 0, all slots are released, `hbusy` is 0 and `hrdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | Marks bit period 0 of the frame |
| rx_a | input | NSTR | Receive streams, group A |
| rx_b | input | NSTR | Receive streams, group B |
| out_en | input | 1 | External output enable |
| idle_hiz | input | 1 | Released slots float (1) or drive high (0) |
| tx_d | output | NSTR | Transmit data |
| tx_oe | output | NSTR | Transmit driver enable |
| hwr | input | 1 | Host write strobe |
| hrd | input | 1 | Host read strobe |
| haddr | input | SW+CW+2 | Region in the top two bits, stream and channel index below |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data, registered |
| hbusy | output | 1 | Connection write held this cycle |

## Verification
The hardest case routes source channel 31 to output channel 0. A design that reads the bank still being filled would send the previous frame's byte here. A message entry carries an out-of-range stream field and an out-of-range source channel is used; a decoder that does not honour the mode or the range check would send a stray memory byte. Host reads of one channel before and after it arrives in the current frame catch a wrong choice of bank. A connection write issued at channel bit 0 must stall for exactly NSTR cycles, and one issued in a free cycle must not stall. The two gating inputs and the idle-level select are toggled one at a time; wrong gating would leave slots driven or floating when they should not be.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NSTR = 2,
  parameter int CHANS = 32,
  localparam int CW = $clog2(CHANS),
  localparam int SW = (NSTR > 1) ? $clog2(NSTR) : 1,
  localparam int AW = SW + CW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_sync,
  input  logic [NSTR-1:0] rx_a,
  input  logic [NSTR-1:0] rx_b,
  input  logic            out_en,
  input  logic            idle_hiz,
  output logic [NSTR-1:0] tx_d,
  output logic [NSTR-1:0] tx_oe,
  input  logic            hwr,
  input  logic            hrd,
  input  logic [AW-1:0]   haddr,
  input  logic [15:0]     hwdata,
  output logic [15:0]     hrdata,
  output logic            hbusy
);
  localparam int IW = SW + CW;
  localparam int FW = CW + 3;
  localparam int DW = IW + 3;
  localparam logic [8:0] CH_LIM = 9'(CHANS);
  localparam logic [3:0] ST_LIM = 4'(NSTR);

  logic [15:0] cmem [2**IW];
  logic [7:0]  dmem [2**DW];
  logic [FW-1:0] pos_q;
  logic [1:0] wbank;
  logic ctrl_on;
  logic [6:0] sha [NSTR];
  logic [6:0] shb [NSTR];
  logic [7:0] osh [NSTR];
  logic [7:0] pend [NSTR];
  logic [NSTR-1:0] oen_q, pen_q;

  wire [FW-1:0] pos_now = frame_sync ? '0 : pos_q;
  wire [2:0]    sub = pos_now[2:0];
  wire [CW-1:0] ch = pos_now[FW-1:3];
  wire [CW-1:0] nch = ch + CW'(1);
  wire          fetch = int'(sub) < NSTR;
  wire [SW-1:0] fs = sub[SW-1:0];

  wire [1:0] bank_prev = (wbank == 2'd0) ? 2'd2 : wbank - 2'd1;
  wire [1:0] bank_old  = (wbank == 2'd2) ? 2'd0 : wbank + 2'd1;
  wire [1:0] rbank = (ch == CW'(CHANS-1)) ? bank_prev : bank_old;

  wire [15:0] ent = cmem[{fs, nch}];
  wire        src_ok = (ent[8:0] < CH_LIM) && (ent[12:9] < ST_LIM);
  wire [7:0]  src_byte = src_ok ? dmem[{ent[13], rbank, ent[9 +: SW], ent[CW-1:0]}] : 8'h00;
  wire [7:0]  next_byte = ent[15] ? ent[7:0] : src_byte;

  wire [1:0]    region = haddr[AW-1:IW];
  wire [IW-1:0] hidx = haddr[IW-1:0];
  wire [1:0]    hbank = (hidx[CW-1:0] < ch) ? wbank : bank_prev;
  wire          cm_wr = hwr && (region == 2'd0);

  assign hbusy = cm_wr && fetch;

  always_ff @(posedge clk) begin
    if (cm_wr && !fetch) cmem[hidx] <= hwdata;
    for (int s = 0; s < NSTR; s++) begin
      if (sub == 3'd7) begin
        dmem[{1'b0, wbank, SW'(s), ch}] <= {sha[s], rx_a[s]};
        dmem[{1'b1, wbank, SW'(s), ch}] <= {shb[s], rx_b[s]};
      end
      sha[s] <= {sha[s][5:0], rx_a[s]};
      shb[s] <= {shb[s][5:0], rx_b[s]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      wbank   <= 2'd0;
      ctrl_on <= 1'b0;
      hrdata  <= 16'h0000;
      oen_q   <= '0;
      pen_q   <= '0;
      for (int s = 0; s < NSTR; s++) begin
        osh[s]  <= 8'h00;
        pend[s] <= 8'h00;
      end
    end else begin
      pos_q <= pos_now + FW'(1);
      if (&pos_now) wbank <= bank_old;
      if (hwr && region == 2'd3) ctrl_on <= hwdata[0];
      if (hrd) begin
        case (region)
          2'd0:    hrdata <= cmem[hidx];
          2'd1:    hrdata <= {8'h00, dmem[{1'b0, hbank, hidx}]};
          2'd2:    hrdata <= {8'h00, dmem[{1'b1, hbank, hidx}]};
          default: hrdata <= {15'h0000, ctrl_on};
        endcase
      end
      for (int s = 0; s < NSTR; s++) begin
        if (fetch && fs == SW'(s)) begin
          pend[s]  <= next_byte;
          pen_q[s] <= ent[14];
        end
        if (sub == 3'd7) begin
          osh[s]   <= pend[s];
          oen_q[s] <= pen_q[s];
        end else begin
          osh[s] <= {osh[s][6:0], 1'b0};
        end
      end
    end
  end

  for (genvar s = 0; s < NSTR; s++) begin : g_tx
    wire act = out_en & ctrl_on & oen_q[s];
    assign tx_d[s]  = act ? osh[s][7] : 1'b1;
    assign tx_oe[s] = act | ~idle_hiz;
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NSTR = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            out_en,
  input logic            idle_hiz,
  input logic [NSTR-1:0] tx_d,
  input logic [NSTR-1:0] tx_oe,
  input logic            hwr,
  input logic            hrd,
  input logic [1:0]      hregion,
  input logic [7:0]      hrdata_hi,
  input logic            hbusy
);
  p_gate_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (&tx_d));

  p_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hiz && !out_en) |-> (tx_oe == '0));

  p_drive_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_hiz |-> (&tx_oe));

  p_stall_cm_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hbusy |-> (hwr && hregion == 2'd0));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hrd && (hregion == 2'd1 || hregion == 2'd2)) |=> (hrdata_hi == 8'h00));
endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .out_en(out_en),
  .idle_hiz(idle_hiz),
  .tx_d(tx_d),
  .tx_oe(tx_oe),
  .hwr(hwr),
  .hrd(hrd),
  .hregion(haddr[AW-1:AW-2]),
  .hrdata_hi(hrdata[15:8]),
  .hbusy(hbusy)
);

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSTR = 2;
  localparam int CHANS = 32;
  localparam int AW = 8;
  localparam int FRAME = CHANS * 8;
  localparam int NVEC = 9;
  // {out stream[31:28], out channel[27:20], kind[19:16], entry[15:0]}
  // kind: 0 routed, 1 message, 2 released, 3 out-of-range source
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_401F, 32'h0050_6205, 32'h11F0_4200, 32'h1071_DEA5, 32'h00C2_2203,
    32'h1140_601F, 32'h01F1_C000, 32'h1010_4001, 32'h0033_4040
  };

  logic clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0, out_en = 1'b0, idle_hiz = 1'b0;
  logic hwr = 1'b0, hrd = 1'b0;
  logic [NSTR-1:0] rx_a = '0, rx_b = '0;
  logic [AW-1:0] haddr = '0;
  logic [15:0] hwdata = '0;
  wire [NSTR-1:0] tx_d, tx_oe;
  wire [15:0] hrdata;
  wire hbusy;

  int total = 0, bad = 0;
  bit running = 0;
  int tb_pos = 0, cur_slot = 0, tb_frame = 0, frames_done = 0;
  logic [7:0] cap [NSTR][CHANS];
  bit cap_hi [NSTR][CHANS];
  bit cap_z [NSTR][CHANS];
  logic [7:0] sh [NSTR];
  bit chi [NSTR];
  bit cz [NSTR];

  tsi_switch #(.NSTR(NSTR), .CHANS(CHANS)) uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_a(rx_a), .rx_b(rx_b),
    .out_en(out_en), .idle_hiz(idle_hiz), .tx_d(tx_d), .tx_oe(tx_oe),
    .hwr(hwr), .hrd(hrd), .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata), .hbusy(hbusy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(int g, int s, int c, int f);
    return 8'(c * 5 + s * 37 + g * 101 + f * 13 + 7);
  endfunction

  always @(negedge clk) begin
    if (running) begin
      for (int s = 0; s < NSTR; s++) begin
        logic [7:0] ba, bb;
        if (tb_pos % 8 == 0) begin chi[s] = 1; cz[s] = 1; end
        sh[s] = {sh[s][6:0], tx_d[s]};
        chi[s] = chi[s] & tx_d[s] & tx_oe[s];
        cz[s] = cz[s] & !tx_oe[s];
        if (tb_pos % 8 == 7) begin
          cap[s][tb_pos/8] = sh[s];
          cap_hi[s][tb_pos/8] = chi[s];
          cap_z[s][tb_pos/8] = cz[s];
        end
        ba = pat(0, s, tb_pos/8, tb_frame);
        bb = pat(1, s, tb_pos/8, tb_frame);
        rx_a[s] = ba[7 - tb_pos % 8];
        rx_b[s] = bb[7 - tb_pos % 8];
      end
      frame_sync = (tb_pos == 0);
      cur_slot = tb_pos;
      if (tb_pos == FRAME - 1) begin
        tb_pos = 0;
        tb_frame++;
        frames_done = tb_frame;
      end else begin
        tb_pos++;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    haddr = a; hwdata = d; hwr = 1'b1;
    #1;
    while (hbusy) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    hwr = 1'b0;
  endtask

  task automatic hread(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk); #1;
    haddr = a; hrd = 1'b1;
    @(posedge clk); #1;
    hrd = 1'b0;
    d = hrdata;
  endtask

  task automatic wait_frames(int n);
    int t;
    t = frames_done + n;
    wait (frames_done == t);
  endtask

  task automatic wait_slot(int m, int v);
    do begin @(negedge clk); #1; end while (cur_slot % m != v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int f, n;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R9", "hrdata after reset", hrdata, 0);
    check("R9", "hbusy after reset", hbusy, 0);
    check("R9", "tx_d released after reset", tx_d, 2'b11);
    check("R9", "tx_oe released after reset", tx_oe, 2'b11);
    hread(AW'(192), rd);
    check("R9", "control bit after reset", rd, 0);

    running = 1;
    for (int i = 0; i < 2 * CHANS; i++) hwrite(AW'(i), 16'h0000);
    for (int i = 0; i < NVEC; i++)
      hwrite(AW'(int'(VEC[i][31:28]) * CHANS + int'(VEC[i][27:20])), VEC[i][15:0]);
    hwrite(AW'(192), 16'h0001);
    out_en = 1'b1;
    hread(AW'(192), rd);
    check("R5", "control bit readback", rd, 1);

    wait (frames_done >= 4);
    f = frames_done - 1;
    for (int i = 0; i < NVEC; i++) begin
      int os, oc, kind, exp;
      logic [15:0] e;
      os = int'(VEC[i][31:28]); oc = int'(VEC[i][27:20]); kind = int'(VEC[i][19:16]);
      e = VEC[i][15:0];
      case (kind)
        0: begin
          exp = pat(int'(e[13]), int'(e[12:9]), int'(e[8:0]), f - 2);
          check("R1 R2", $sformatf("routed byte vec %0d", i), cap[os][oc], exp);
        end
        1: check("R3", $sformatf("message byte vec %0d", i), cap[os][oc], int'(e[7:0]));
        2: check("R4", $sformatf("released high vec %0d", i), cap_hi[os][oc], 1);
        default: check("R6", $sformatf("out-of-range source vec %0d", i), cap[os][oc], 0);
      endcase
    end
    check("R4", "unprogrammed slot released", cap_hi[1][10], 1);

    hread(AW'(64 + 32 + 3), rd);
    check("R7", "group A s1 c3 last frame", rd, pat(0, 1, 3, f));
    hread(AW'(128 + 3), rd);
    check("R7", "group B s0 c3 last frame", rd, pat(1, 0, 3, f));
    wait_slot(FRAME, 84);
    hread(AW'(64 + 32 + 3), rd);
    check("R7", "group A s1 c3 current frame", rd, pat(0, 1, 3, f + 1));
    hread(AW'(64 + 32 + 20), rd);
    check("R7", "group A s1 c20 not yet arrived", rd, pat(0, 1, 20, f));

    wait_slot(8, 0);
    haddr = AW'(2); hwdata = 16'hC05A; hwr = 1'b1;
    #1;
    check("R8", "hbusy at channel bit 0", hbusy, 1);
    n = 0;
    while (hbusy) begin n++; @(negedge clk); #1; end
    @(posedge clk); #1; hwr = 1'b0;
    check("R8", "stall length", n, NSTR);
    hread(AW'(2), rd);
    check("R8", "entry readback", rd, 16'hC05A);
    wait_slot(8, NSTR);
    haddr = AW'(2); hwdata = 16'hC05A; hwr = 1'b1;
    #1;
    check("R8", "no stall in free cycle", hbusy, 0);
    @(posedge clk); #1; hwr = 1'b0;
    wait_frames(2);
    check("R3", "message after stalled write", cap[0][2], 8'h5A);

    out_en = 1'b0;
    wait_frames(2);
    check("R5", "out_en low releases routed slot", cap_hi[0][0], 1);
    check("R5", "out_en low releases slot 5", cap_hi[0][5], 1);
    idle_hiz = 1'b1;
    wait_frames(2);
    check("R5", "out_en low floats slot 5", cap_z[0][5], 1);
    out_en = 1'b1;
    wait_frames(2);
    f = frames_done - 1;
    check("R4", "disabled slot floats", cap_z[0][12], 1);
    check("R4", "enabled slot driven", cap_z[0][5], 0);
    check("R2", "routed with float select", cap[0][5], pat(1, 1, 5, f - 2));
    hwrite(AW'(192), 16'h0000);
    idle_hiz = 1'b0;
    wait_frames(2);
    check("R5", "control bit clear releases", cap_hi[0][5], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule